// File: doc/BRIEF.md
# Flash Operation Status Generator

This block sits on the read path of a parallel NOR flash array. It produces the bytes the device returns while an internal program or erase runs. A command decoder outside the block tells it which operation is in progress and when the last write of the command sequence has landed. The embedded algorithm reports completion and pulse-count overflow, and a separate timer reports that the sector-erase acceptance window has closed. From these inputs the block builds a status byte. That byte carries a device-wide toggle bit, a per-sector toggle bit, a failure flag and an erase-timer flag. Whenever no operation is visible to the reader, the block passes the array data straight through.

Both toggle bits change only on the rising edge of the read strobe. Software that polls twice in a row therefore sees a changed bit while the operation is still running, and a steady bit once it has finished. Two extra cases are covered. A program aimed at a protected sector, or an erase whose selected sectors are all protected, runs no algorithm. For these the block shows a short fixed toggle window and then drops back to array reads. The window lengths are given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `flash_op_status`

## Requirements
- R1: While no operation is shown, `rd_data` equals `arr_data` in the same cycle, including straight after reset.
- R2: In a program, sector erase or chip erase that is running (`op_mode` 1, 2, 3), status bit 6 inverts on every rising edge of `rd_stb`, whatever the address. With no rising edge, it holds.
- R3: In erase suspend (`op_mode` 4), bit 6 holds across reads. A read of a sector not selected for erase returns `arr_data`.
- R4: In erase-suspend-program (`op_mode` 5), bit 6 inverts per read until `alg_done` is seen. After that it holds until `op_mode` changes.
- R5: Status bit 2 inverts on a read-strobe rising edge only when the read address lies in a sector selected for erase, in modes 2 to 5. In chip erase every sector counts as selected. The sector is the top log2(N_SECT) address bits.
- R6: A `cmd_go` in program mode whose `prog_addr` sector is protected shows status for exactly PROG_WIN_US × CLK_FREQ_HZ / 1e6 cycles, with bit 6 toggling, and then returns to array data.
- R7: A sector-erase `cmd_go` whose selected sectors are all protected (or chip erase with every sector protected) shows toggling status for ERASE_WIN_US × CLK_FREQ_HZ / 1e6 cycles, then array data.
- R8: `pulse_ovf` during an operation sets status bit 5. The bit holds, and `alg_done` does not end the operation, until `reset_cmd`. After `reset_cmd`, the next cycle shows array data.
- R9: Status bit 3 reads 0 after each sector-erase `cmd_go` (an additional one clears it again) and 1 after `sect_tmo`. A chip-erase `cmd_go` sets it to 1.
- R10: `alg_done` in program, sector-erase or chip-erase mode, with no failure flagged, returns the block to array data on the next cycle.
- R11: The status byte reads 0 in bits 7, 4, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read strobe, synchronous to clk; each rising edge is one read |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | 8 | Array data for the current read address |
| op_mode | input | 3 | Operation: 0 none, 1 program, 2 sector erase, 3 chip erase, 4 erase suspend, 5 erase-suspend-program |
| cmd_go | input | 1 | One-cycle pulse at the final write of a command sequence |
| reset_cmd | input | 1 | One-cycle pulse of the reset command |
| prog_addr | input | ADDR_W | Target address of a program command |
| erase_sel | input | N_SECT | Sectors selected for erase |
| sect_prot | input | N_SECT | Protected sectors |
| alg_done | input | 1 | Embedded algorithm completion pulse |
| pulse_ovf | input | 1 | Embedded algorithm pulse-count overflow |
| sect_tmo | input | 1 | Sector-erase acceptance timeout expired |
| rd_data | output | 8 | Read data: status byte or array data |

## Verification
On every cycle, the assertions check the following:
- both toggle bits stay put without a fresh read edge;
- the per-sector bit stays put on reads outside the selected sectors;
- the device-wide bit is frozen in erase suspend;
- the failure flag is sticky;
- the reset command restores array reads;
- each sector-erase command clears the timer flag.

Other properties span many cycles or depend on a sequence of modes, so only the bench scenarios can show them. These are the exact lengths of the two protected-sector windows, the stop of toggling after the suspended program completes, the resume of erase after it, and chip erase treating every sector as selected.

// File: rtl/flash_sts_pkg.sv
// Shared types for the flash operation status generator.
// Assumes op_mode values 6 and 7 are never driven; they behave as "none".
package flash_sts_pkg;

    typedef enum logic [2:0] {
        OPM_NONE     = 3'd0,
        OPM_PROG     = 3'd1,
        OPM_SERASE   = 3'd2,
        OPM_CERASE   = 3'd3,
        OPM_SUSP     = 3'd4,
        OPM_SUSPPROG = 3'd5
    } opm_e;

    typedef enum logic [1:0] {
        ST_ARRAY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_GUARD = 2'd2
    } sts_state_e;

    localparam int unsigned BIT_TOG_DEV  = 6;
    localparam int unsigned BIT_FAIL     = 5;
    localparam int unsigned BIT_ETIMER   = 3;
    localparam int unsigned BIT_TOG_SECT = 2;

    // True for modes in which an embedded algorithm runs to completion
    function automatic logic is_run_mode(opm_e m);
        return (m == OPM_PROG) || (m == OPM_SERASE) || (m == OPM_CERASE);
    endfunction

    // True for modes in which sector selection for erase is meaningful
    function automatic logic is_erase_ctx(opm_e m);
        return (m == OPM_SERASE) || (m == OPM_CERASE) ||
               (m == OPM_SUSP)   || (m == OPM_SUSPPROG);
    endfunction

endpackage

// File: rtl/flash_sts_sect.sv
// Sector decode: maps read and program addresses to sector indices and
// evaluates the selection and protection masks.
// Assumes N_SECT is a power of two; the sector is the top address bits.
module flash_sts_sect #(
    parameter int N_SECT = 8,
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [N_SECT-1:0] erase_sel,
    input  logic [N_SECT-1:0] sect_prot,
    input  logic              chip_mode,
    output logic              rd_hit,
    output logic              prog_prot,
    output logic              sel_all_prot,
    output logic              chip_all_prot
);
    localparam int SECT_W   = (N_SECT > 1) ? $clog2(N_SECT) : 1;
    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic [SECT_W-1:0] rd_idx;
    logic [SECT_W-1:0] pg_idx;
    logic [N_SECT-1:0] sel_eff;
    logic [N_SECT-1:0] sel_open;

    // Sector index of the read and program addresses
    always_comb begin
        rd_idx = SECT_W'(rd_addr >> SECT_LSB);
        pg_idx = SECT_W'(prog_addr >> SECT_LSB);
    end

    // Per-sector effective selection and selected-but-unprotected flags
    for (genvar i = 0; i < N_SECT; i++) begin : g_sect
        assign sel_eff[i]  = chip_mode | erase_sel[i];
        assign sel_open[i] = erase_sel[i] & ~sect_prot[i];
    end

    // Summary flags used by the sequencer and toggle logic
    always_comb begin
        rd_hit        = sel_eff[rd_idx];
        prog_prot     = sect_prot[pg_idx];
        sel_all_prot  = ~|sel_open;
        chip_all_prot = &sect_prot;
    end
endmodule

// File: rtl/flash_sts_seq.sv
// Operation sequencer: tracks whether status or array data is shown,
// runs the protected-sector guard window, and holds the failure,
// erase-timer and suspended-program-done flags.
// Assumes cmd_go, reset_cmd and alg_done are single-cycle pulses.
module flash_sts_seq
    import flash_sts_pkg::*;
#(
    parameter int PROG_WIN  = 100,
    parameter int ERASE_WIN = 5000,
    parameter int CNT_W     = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  opm_e       mode,
    input  logic       cmd_go,
    input  logic       reset_cmd,
    input  logic       prog_prot,
    input  logic       sel_all_prot,
    input  logic       chip_all_prot,
    input  logic       alg_done,
    input  logic       pulse_ovf,
    input  logic       sect_tmo,
    output sts_state_e st,
    output logic       fail_q,
    output logic       dq3_q,
    output logic       sp_done_q
);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_WIN - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_WIN - 1);

    logic [CNT_W-1:0] win_cnt;

    // Main state and guard-window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_ARRAY;
            win_cnt <= '0;
        end else if (reset_cmd) begin
            st <= ST_ARRAY;
        end else if (cmd_go) begin
            unique case (mode)
                OPM_PROG: begin
                    st      <= prog_prot ? ST_GUARD : ST_BUSY;
                    win_cnt <= PROG_LAST;
                end
                OPM_SERASE: begin
                    if (st != ST_BUSY) begin
                        st      <= sel_all_prot ? ST_GUARD : ST_BUSY;
                        win_cnt <= ERASE_LAST;
                    end
                end
                OPM_CERASE: begin
                    st      <= chip_all_prot ? ST_GUARD : ST_BUSY;
                    win_cnt <= ERASE_LAST;
                end
                default: ;
            endcase
        end else begin
            unique case (st)
                ST_BUSY: begin
                    if (alg_done && is_run_mode(mode) && !fail_q && !pulse_ovf)
                        st <= ST_ARRAY;
                end
                ST_GUARD: begin
                    if (win_cnt == '0) st <= ST_ARRAY;
                    else               win_cnt <= win_cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Sticky failure flag, cleared only by the reset command
    always_ff @(posedge clk) begin
        if (!rst_n)                        fail_q <= 1'b0;
        else if (reset_cmd)                fail_q <= 1'b0;
        else if (st == ST_BUSY && pulse_ovf) fail_q <= 1'b1;
    end

    // Erase-acceptance timer flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq3_q <= 1'b0;
        end else if (!reset_cmd && cmd_go && mode == OPM_SERASE) begin
            dq3_q <= 1'b0;
        end else if (!reset_cmd && cmd_go && mode == OPM_CERASE) begin
            dq3_q <= 1'b1;
        end else if (sect_tmo) begin
            dq3_q <= 1'b1;
        end
    end

    // Completion marker for a program run inside erase suspend
    always_ff @(posedge clk) begin
        if (!rst_n)                         sp_done_q <= 1'b0;
        else if (reset_cmd || cmd_go)       sp_done_q <= 1'b0;
        else if (mode != OPM_SUSPPROG)      sp_done_q <= 1'b0;
        else if (st == ST_BUSY && alg_done) sp_done_q <= 1'b1;
    end
endmodule

// File: rtl/flash_sts_toggle.sv
// Toggle bits: detects rising edges of the read strobe and inverts the
// device-wide and per-sector toggle bits when each is enabled.
// Assumes rd_stb is synchronous to clk.
module flash_sts_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    input  logic act_dev,
    input  logic act_sect,
    output logic stb_q,
    output logic tog_dev,
    output logic tog_sect
);
    logic rd_rise;

    // Rising edge of the read strobe
    assign rd_rise = rd_stb & ~stb_q;

    // Strobe history and the two toggle bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q    <= 1'b0;
            tog_dev  <= 1'b0;
            tog_sect <= 1'b0;
        end else begin
            stb_q <= rd_stb;
            if (rd_rise && act_dev)  tog_dev  <= ~tog_dev;
            if (rd_rise && act_sect) tog_sect <= ~tog_sect;
        end
    end
endmodule

// File: rtl/flash_op_status.sv
// Flash operation status generator top: combines the sector decode,
// sequencer and toggle bits into the byte returned on reads.
// Assumes all inputs are synchronous to clk.
module flash_op_status
    import flash_sts_pkg::*;
#(
    parameter int N_SECT       = 8,
    parameter int ADDR_W       = 16,
    parameter int CLK_FREQ_HZ  = 50_000_000,
    parameter int PROG_WIN_US  = 2,
    parameter int ERASE_WIN_US = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_data,
    input  logic [2:0]        op_mode,
    input  logic              cmd_go,
    input  logic              reset_cmd,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [N_SECT-1:0] erase_sel,
    input  logic [N_SECT-1:0] sect_prot,
    input  logic              alg_done,
    input  logic              pulse_ovf,
    input  logic              sect_tmo,
    output logic [7:0]        rd_data
);
    localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int PROG_WIN   = CYC_PER_US * PROG_WIN_US;
    localparam int ERASE_WIN  = CYC_PER_US * ERASE_WIN_US;
    localparam int WIN_MAX    = (PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN;
    localparam int CNT_W      = $clog2(WIN_MAX + 1);

    opm_e       mode;
    sts_state_e st;
    logic       rd_hit, prog_prot, sel_all_prot, chip_all_prot;
    logic       fail_q, dq3_q, sp_done_q;
    logic       stb_q, tog_dev, tog_sect;
    logic       act_dev, act_sect, show_arr;
    logic [7:0] sts_byte;

    // Operation mode in typed form
    assign mode = opm_e'(op_mode);

    flash_sts_sect #(
        .N_SECT (N_SECT),
        .ADDR_W (ADDR_W)
    ) u_sect (
        .rd_addr       (rd_addr),
        .prog_addr     (prog_addr),
        .erase_sel     (erase_sel),
        .sect_prot     (sect_prot),
        .chip_mode     (mode == OPM_CERASE),
        .rd_hit        (rd_hit),
        .prog_prot     (prog_prot),
        .sel_all_prot  (sel_all_prot),
        .chip_all_prot (chip_all_prot)
    );

    flash_sts_seq #(
        .PROG_WIN  (PROG_WIN),
        .ERASE_WIN (ERASE_WIN),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .cmd_go        (cmd_go),
        .reset_cmd     (reset_cmd),
        .prog_prot     (prog_prot),
        .sel_all_prot  (sel_all_prot),
        .chip_all_prot (chip_all_prot),
        .alg_done      (alg_done),
        .pulse_ovf     (pulse_ovf),
        .sect_tmo      (sect_tmo),
        .st            (st),
        .fail_q        (fail_q),
        .dq3_q         (dq3_q),
        .sp_done_q     (sp_done_q)
    );

    // Enables for the two toggle bits
    always_comb begin
        act_dev  = (st == ST_GUARD) ||
                   (st == ST_BUSY && (is_run_mode(mode) ||
                                      (mode == OPM_SUSPPROG && !sp_done_q)));
        act_sect = (st != ST_ARRAY) && is_erase_ctx(mode) && rd_hit;
    end

    flash_sts_toggle u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .act_dev  (act_dev),
        .act_sect (act_sect),
        .stb_q    (stb_q),
        .tog_dev  (tog_dev),
        .tog_sect (tog_sect)
    );

    // Assemble the status byte and choose it or array data
    always_comb begin
        sts_byte               = '0;
        sts_byte[BIT_TOG_DEV]  = tog_dev;
        sts_byte[BIT_FAIL]     = fail_q;
        sts_byte[BIT_ETIMER]   = dq3_q;
        sts_byte[BIT_TOG_SECT] = tog_sect;
        show_arr = (st == ST_ARRAY) || (st == ST_BUSY && mode == OPM_SUSP && !rd_hit);
        rd_data  = show_arr ? arr_data : sts_byte;
    end
endmodule

// File: rtl/flash_op_status_chk.sv
// Assertion checker for flash_op_status, attached with bind below.
// Observes ports and the flags passed between the submodules.
module flash_op_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       reset_cmd,
    input logic       cmd_go,
    input logic [2:0] op_mode,
    input logic [7:0] arr_data,
    input logic [7:0] rd_data,
    input logic       stb_q,
    input logic       tog_dev,
    input logic       tog_sect,
    input logic       rd_hit,
    input logic       fail_q,
    input logic       dq3_q,
    input logic [1:0] st
);
    // No read edge leaves the device toggle bit unchanged
    assert_dev_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb || stb_q) |=> $stable(tog_dev));

    // No read edge leaves the sector toggle bit unchanged
    assert_sect_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb || stb_q) |=> $stable(tog_sect));

    // Erase suspend freezes the device toggle bit
    assert_susp_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd1 && op_mode == 3'd4) |=> $stable(tog_dev));

    // Reads outside the selected sectors never move the sector toggle bit
    assert_unsel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(tog_sect));

    // Failure flag persists until the reset command
    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !reset_cmd) |=> fail_q);

    // Reset command returns to array reads
    assert_reset_array_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> (rd_data == arr_data));

    // Each sector-erase command clears the timer flag
    assert_etimer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !reset_cmd && op_mode == 3'd2) |=> !dq3_q);
endmodule

bind flash_op_status flash_op_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .reset_cmd (reset_cmd),
    .cmd_go    (cmd_go),
    .op_mode   (op_mode),
    .arr_data  (arr_data),
    .rd_data   (rd_data),
    .stb_q     (stb_q),
    .tog_dev   (tog_dev),
    .tog_sect  (tog_sect),
    .rd_hit    (rd_hit),
    .fail_q    (fail_q),
    .dq3_q     (dq3_q),
    .st        (st)
);

// File: tb/flash_op_status_bench.sv
// Bench for flash_op_status: a behavioural reference model is stepped on
// every rising edge and compared with rd_data on every falling edge;
// scenario checks add hand-derived expectations.
module flash_op_status_bench;
    localparam int PROG_CYC  = 100;
    localparam int ERASE_CYC = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  arr_data = 8'hA5;
    logic [2:0]  op_mode = '0;
    logic        cmd_go = 1'b0;
    logic        reset_cmd = 1'b0;
    logic [15:0] prog_addr = '0;
    logic [7:0]  erase_sel = '0;
    logic [7:0]  sect_prot = '0;
    logic        alg_done = 1'b0;
    logic        pulse_ovf = 1'b0;
    logic        sect_tmo = 1'b0;
    logic [7:0]  rd_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done_flag = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    flash_op_status u_flash_op_status (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .arr_data(arr_data), .op_mode(op_mode), .cmd_go(cmd_go),
        .reset_cmd(reset_cmd), .prog_addr(prog_addr), .erase_sel(erase_sel),
        .sect_prot(sect_prot), .alg_done(alg_done), .pulse_ovf(pulse_ovf),
        .sect_tmo(sect_tmo), .rd_data(rd_data)
    );

    // ---------------- reference model ----------------
    int m_st = 0;          // 0 array, 1 running, 2 guard window
    int m_cnt = 0;
    bit m_t6 = 0, m_t2 = 0, m_fail = 0, m_tmr = 0, m_spd = 0, m_prev = 0;

    function automatic bit sel_hit(logic [15:0] a);
        return (op_mode == 3) || erase_sel[a[15:13]];
    endfunction

    function automatic logic [7:0] model_out();
        logic [7:0] s;
        if (m_st == 0) return arr_data;
        if (m_st == 1 && op_mode == 4 && !sel_hit(rd_addr)) return arr_data;
        s = 8'h00;
        s[6] = m_t6; s[5] = m_fail; s[3] = m_tmr; s[2] = m_t2;
        return s;
    endfunction

    always @(posedge clk) begin
        bit rise, a6, a2, runmode;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_t6 = 0; m_t2 = 0;
            m_fail = 0; m_tmr = 0; m_spd = 0; m_prev = 0;
        end else begin
            runmode = (op_mode == 1) || (op_mode == 2) || (op_mode == 3);
            rise = rd_stb && !m_prev;
            a6 = (m_st == 2) || (m_st == 1 && (runmode || (op_mode == 5 && !m_spd)));
            a2 = (m_st != 0) && (op_mode >= 2 && op_mode <= 5) && sel_hit(rd_addr);
            if (rise && a6) m_t6 = !m_t6;
            if (rise && a2) m_t2 = !m_t2;
            m_prev = rd_stb;
            // flags
            if (reset_cmd) m_fail = 0;
            else if (m_st == 1 && pulse_ovf) m_fail = 1;
            if (!reset_cmd && cmd_go && op_mode == 2) m_tmr = 0;
            else if (!reset_cmd && cmd_go && op_mode == 3) m_tmr = 1;
            else if (sect_tmo) m_tmr = 1;
            if (reset_cmd || cmd_go || op_mode != 5) m_spd = 0;
            else if (m_st == 1 && alg_done) m_spd = 1;
            // state
            if (reset_cmd) m_st = 0;
            else if (cmd_go) begin
                if (op_mode == 1) begin
                    m_st = sect_prot[prog_addr[15:13]] ? 2 : 1; m_cnt = PROG_CYC;
                end else if (op_mode == 2 && m_st != 1) begin
                    m_st = ((erase_sel & ~sect_prot) == 0) ? 2 : 1; m_cnt = ERASE_CYC;
                end else if (op_mode == 3) begin
                    m_st = (&sect_prot) ? 2 : 1; m_cnt = ERASE_CYC;
                end
            end else if (m_st == 1) begin
                if (alg_done && runmode && !m_fail && !pulse_ovf) m_st = 0;
            end else if (m_st == 2) begin
                m_cnt--;
                if (m_cnt == 0) m_st = 0;
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            n_cmp++;
            if (rd_data !== model_out()) begin
                n_bad++;
                $display("FAIL %s per-clock: actual=%h expected=%h at %0t",
                         cur_req, rd_data, model_out(), $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] v);
        tick(); rd_addr = a; rd_stb = 1'b1;
        @(negedge clk); v = rd_data; #1; rd_stb = 1'b0;
        tick();
    endtask

    task automatic go(input logic [2:0] m);
        tick(); op_mode = m; cmd_go = 1'b1;
        tick(); cmd_go = 1'b0;
    endtask

    task automatic pulse_done();
        tick(); alg_done = 1'b1; tick(); alg_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [15:0] sa(input int s);
        return 16'(s << 13);
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] v1, v2, v3;
        idle(3);
        rst_n = 1'b1;
        tick();
        cur_req = "R1";
        chk("R1 reset passthrough", rd_data, 8'hA5);
        arr_data = 8'h3C; tick();
        chk("R1 passthrough change", rd_data, 8'h3C);
        do_read(sa(3), v1);
        chk("R1 read while idle", v1, 8'h3C);

        // Program, unprotected sector 1
        cur_req = "R2";
        arr_data = 8'hFF; sect_prot = 8'h81; prog_addr = sa(1);
        go(3'd1);
        do_read(sa(0), v1);
        do_read(sa(6), v2);
        do_read(sa(2), v3);
        chk("R2 dev bit flips", {7'd0, v1[6] ^ v2[6]}, 8'd1);
        chk("R2 dev bit flips again", {7'd0, v2[6] ^ v3[6]}, 8'd1);
        cur_req = "R11";
        chk("R11 zero bits", v1 & 8'h93, 8'h00);
        cur_req = "R10";
        pulse_done(); tick();
        chk("R10 done to array", rd_data, 8'hFF);

        // Sector erase on sectors 1 and 2
        cur_req = "R9";
        erase_sel = 8'b0000_0110;
        go(3'd2);
        do_read(sa(1), v1);
        chk("R9 timer low after cmd", {7'd0, v1[3]}, 8'd0);
        cur_req = "R5";
        do_read(sa(2), v1);
        do_read(sa(2), v2);
        chk("R5 sect bit flips on selected", {7'd0, v1[2] ^ v2[2]}, 8'd1);
        do_read(sa(5), v1);
        do_read(sa(5), v2);
        chk("R5 sect bit holds on unselected", {7'd0, v1[2] ^ v2[2]}, 8'd0);
        cur_req = "R9";
        tick(); sect_tmo = 1'b1; tick(); sect_tmo = 1'b0;
        do_read(sa(1), v1);
        chk("R9 timer high after timeout", {7'd0, v1[3]}, 8'd1);
        erase_sel = 8'b0000_1110;
        go(3'd2);
        do_read(sa(3), v1);
        chk("R9 extra sector clears timer", {7'd0, v1[3]}, 8'd0);

        // Erase suspend
        cur_req = "R3";
        tick(); op_mode = 3'd4;
        do_read(sa(1), v1);
        do_read(sa(2), v2);
        chk("R3 dev bit frozen", {7'd0, v1[6] ^ v2[6]}, 8'd0);
        chk("R3 sect bit still flips", {7'd0, v1[2] ^ v2[2]}, 8'd1);
        arr_data = 8'h5A;
        do_read(sa(6), v1);
        chk("R3 unselected gives array", v1, 8'h5A);

        // Program inside erase suspend
        cur_req = "R4";
        tick(); op_mode = 3'd5;
        do_read(sa(6), v1);
        do_read(sa(6), v2);
        chk("R4 dev bit flips", {7'd0, v1[6] ^ v2[6]}, 8'd1);
        pulse_done();
        do_read(sa(6), v1);
        do_read(sa(6), v2);
        chk("R4 dev bit stops", {7'd0, v1[6] ^ v2[6]}, 8'd0);
        tick(); op_mode = 3'd2;
        do_read(sa(6), v1);
        do_read(sa(6), v2);
        chk("R4 resume flips again", {7'd0, v1[6] ^ v2[6]}, 8'd1);
        cur_req = "R10";
        pulse_done(); tick();
        chk("R10 erase done to array", rd_data, 8'h5A);

        // Overflow failure
        cur_req = "R8";
        prog_addr = sa(4);
        go(3'd1);
        tick(); pulse_ovf = 1'b1; tick(); pulse_ovf = 1'b0;
        pulse_done();
        do_read(sa(4), v1);
        chk("R8 fail bit set and still status", v1 & 8'hA0, 8'h20);
        tick(); reset_cmd = 1'b1; tick(); reset_cmd = 1'b0;
        chk("R8 reset to array", rd_data, 8'h5A);

        // Program into protected sector 7
        cur_req = "R6";
        prog_addr = sa(7);
        go(3'd1);
        idle(40);
        chk("R6 status during window", {7'd0, rd_data[7]}, 8'd0);
        do_read(sa(0), v1);
        do_read(sa(0), v2);
        chk("R6 window toggles", {7'd0, v1[6] ^ v2[6]}, 8'd1);
        idle(PROG_CYC);
        chk("R6 window over", rd_data, 8'h5A);

        // Erase of protected sectors only
        cur_req = "R7";
        erase_sel = 8'b1000_0001;
        go(3'd2);
        do_read(sa(3), v1);
        do_read(sa(3), v2);
        chk("R7 window toggles", {7'd0, v1[6] ^ v2[6]}, 8'd1);
        idle(ERASE_CYC - 200);
        chk("R7 still in window", {7'd0, rd_data[7]}, 8'd0);
        idle(300);
        chk("R7 window over", rd_data, 8'h5A);

        // Chip erase: every sector selected, timer reads 1
        cur_req = "R9";
        erase_sel = 8'h00;
        go(3'd3);
        do_read(sa(5), v1);
        chk("R9 chip erase timer high", {7'd0, v1[3]}, 8'd1);
        cur_req = "R5";
        do_read(sa(5), v2);
        chk("R5 chip erase sect bit flips", {7'd0, v1[2] ^ v2[2]}, 8'd1);
        cur_req = "R10";
        pulse_done(); tick();
        chk("R10 chip erase done", rd_data, 8'h5A);

        idle(4);
        finish_run();
    end
endmodule